// File: doc/BRIEF.md
# Stack Pointer Unit with Pre-Decremented Shadow

This block keeps the stack pointer of a processor core together with a second register that already holds the address of the top stack word. Because the stack grows upward by a fixed word step, the top word sits one step below the stack pointer. Holding that address ready lets a pop start its memory read at once, with no address arithmetic first. The unit takes pop and push requests and explicit loads of the stack pointer. It reports the address of each pop read and the execution cycle in which that read happens, and the address of each push write. It updates both registers as it goes. The memory and the data path lie outside the block.

A validity bit goes with the shadow register. An explicit load of the stack pointer clears it. The first pop after that spends one extra cycle recomputing the shadow, so its read falls in cycle 2, and `ready` drops for that cycle. Every later pop, and every pop after a push, reads in cycle 1. A pop requested in the same cycle as an explicit load is a programming error and raises a flag.

Top module: `sp_shadow_unit`

## Requirements
- R1: After reset: `sp` equals the parameter RESET_SP, `shadowValid` is 0, `ready` is 1, and `rdValid`, `wrValid`, `err` and `rdCycle` are all 0.
- R2: A pop accepted while `shadowValid` is 1 has the following effects after the accepting clock edge. `rdValid` is 1. `rdAddr` equals the old `sp` minus STEP. `rdCycle` is 1 (encoded 2'd1). `sp` becomes the old `sp` minus STEP.
- R3: A pop accepted while `shadowValid` is 0 drops `ready` for one cycle, and `rdValid` stays 0 in that cycle. After the next edge, `rdValid` is 1, `rdCycle` is 2 (encoded 2'd2), `rdAddr` equals the old `sp` minus STEP, and `sp` takes that same value.
- R4: Only the first pop after invalidation is slow. When a slow pop completes, `shadowValid` is 1 and the following pop completes as in R2.
- R5: An accepted explicit load (`spWrEn`) sets `sp` to `spWrData` and clears `shadowValid` after the edge.
- R6: An accepted push, with no pop or load in the same cycle, has the following effects after the edge. `wrValid` is 1. `wrAddr` equals the old `sp`. `sp` grows by STEP. `shadowValid` is 1.
- R7: A pop and an explicit load in the same accepted cycle raise `err` for exactly one cycle. The load takes effect as in R5, and the pop is discarded (`rdValid` stays 0).
- R8: A pop and a push in the same accepted cycle serve the pop only. `wrValid` stays 0, and `sp` ends as R2 gives.
- R9: Requests presented while `ready` is 0 are ignored. No write is issued for them, and `sp` after the pending pop completes is as R3 gives.
- R10: `rdValid` and `wrValid` are never high together. Each is high for one cycle per accepted operation. `rdCycle` is 0 whenever `rdValid` is 0.
- R11: Whenever `shadowValid` is 1, the shadow register equals `sp` minus STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| popReq | input | 1 | Pop request |
| pushReq | input | 1 | Push request |
| spWrEn | input | 1 | Explicit stack pointer load |
| spWrData | input | ADDR_W | Value for the explicit load |
| ready | output | 1 | Unit accepts requests this cycle |
| rdValid | output | 1 | Pop read issued |
| rdAddr | output | ADDR_W | Pop read address |
| rdCycle | output | 2 | Execution cycle of the pop read (1 or 2) |
| wrValid | output | 1 | Push write issued |
| wrAddr | output | ADDR_W | Push write address |
| sp | output | ADDR_W | Current stack pointer |
| shadowValid | output | 1 | Shadow register holds sp minus STEP |
| err | output | 1 | Pop and explicit load collided |

## Verification
A shadow register that drifts from `sp` minus STEP shows up as a wrong `rdAddr` on the very next fast pop, one edge after it is accepted. A validity bit left set after an explicit load shows up in the same way, and the bench follows each load with a pop. A stuck or missing validity bit shows as the wrong `rdCycle`, or as `ready` failing to drop, in the cycle right after the pop is accepted. A mis-sequenced recompute shows as a wrong `sp` in the following cycle.

// File: rtl/sp_shadow_pkg.sv
package sp_shadow_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CALC = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic ldSp;
    logic doRecalc;
    logic doPop;
    logic slowPop;
    logic doPush;
  } strobes_t;

  localparam logic [1:0] CYC_NONE = 2'd0;
  localparam logic [1:0] CYC_FAST = 2'd1;
  localparam logic [1:0] CYC_SLOW = 2'd2;

endpackage

// File: rtl/sp_shadow_ctrl.sv
module sp_shadow_ctrl
  import sp_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     popReq,
  input  logic     pushReq,
  input  logic     spWrEn,
  input  logic     shadowValid,
  output strobes_t strb,
  output logic     ready,
  output logic     err
);

  ctrlState_e state, nextState;
  logic       errNext;

  assign ready = (state == ST_IDLE);

  always_comb begin
    strb      = '0;
    errNext   = 1'b0;
    nextState = state;
    if (state == ST_CALC) begin
      strb.doPop   = 1'b1;
      strb.slowPop = 1'b1;
      nextState    = ST_IDLE;
    end else if (spWrEn) begin
      strb.ldSp = 1'b1;
      errNext   = popReq;
    end else if (popReq) begin
      if (shadowValid) begin
        strb.doPop = 1'b1;
      end else begin
        strb.doRecalc = 1'b1;
        nextState     = ST_CALC;
      end
    end else if (pushReq) begin
      strb.doPush = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nextState;
      err   <= errNext;
    end
  end

endmodule

// File: rtl/sp_shadow_dpath.sv
module sp_shadow_dpath
  import sp_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STEP     = 8,
  parameter logic [ADDR_W-1:0] RESET_SP = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] spWrData,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] shadowSp,
  output logic              shadowValid,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [1:0]        rdCycle,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] spMinus;
  logic [ADDR_W-1:0] spPlus;
  logic [ADDR_W-1:0] shadowMinus;

  assign spMinus     = sp - STEP_V;
  assign spPlus      = sp + STEP_V;
  assign shadowMinus = shadowSp - STEP_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp          <= RESET_SP;
      shadowSp    <= '0;
      shadowValid <= 1'b0;
      rdValid     <= 1'b0;
      rdAddr      <= '0;
      rdCycle     <= CYC_NONE;
      wrValid     <= 1'b0;
      wrAddr      <= '0;
    end else begin
      rdValid <= 1'b0;
      wrValid <= 1'b0;
      rdCycle <= CYC_NONE;
      if (strb.ldSp) begin
        sp          <= spWrData;
        shadowValid <= 1'b0;
      end
      if (strb.doRecalc) begin
        shadowSp    <= spMinus;
        shadowValid <= 1'b1;
      end
      if (strb.doPop) begin
        sp       <= shadowSp;
        shadowSp <= shadowMinus;
        rdValid  <= 1'b1;
        rdAddr   <= shadowSp;
        rdCycle  <= strb.slowPop ? CYC_SLOW : CYC_FAST;
      end
      if (strb.doPush) begin
        wrValid     <= 1'b1;
        wrAddr      <= sp;
        sp          <= spPlus;
        shadowSp    <= sp;
        shadowValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sp_shadow_unit.sv
module sp_shadow_unit
  import sp_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STEP     = 8,
  parameter logic [ADDR_W-1:0] RESET_SP = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              popReq,
  input  logic              pushReq,
  input  logic              spWrEn,
  input  logic [ADDR_W-1:0] spWrData,
  output logic              ready,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [1:0]        rdCycle,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] sp,
  output logic              shadowValid,
  output logic              err
);

  strobes_t          strb;
  logic [ADDR_W-1:0] shadowSp;

  sp_shadow_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .popReq      (popReq),
    .pushReq     (pushReq),
    .spWrEn      (spWrEn),
    .shadowValid (shadowValid),
    .strb        (strb),
    .ready       (ready),
    .err         (err)
  );

  sp_shadow_dpath #(
    .ADDR_W   (ADDR_W),
    .STEP     (STEP),
    .RESET_SP (RESET_SP)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .spWrData    (spWrData),
    .sp          (sp),
    .shadowSp    (shadowSp),
    .shadowValid (shadowValid),
    .rdValid     (rdValid),
    .rdAddr      (rdAddr),
    .rdCycle     (rdCycle),
    .wrValid     (wrValid),
    .wrAddr      (wrAddr)
  );

endmodule

// File: rtl/sp_shadow_chk.sv
module sp_shadow_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              popReq,
  input logic              pushReq,
  input logic              spWrEn,
  input logic [ADDR_W-1:0] spWrData,
  input logic              ready,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [1:0]        rdCycle,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] shadowSp,
  input logic              shadowValid,
  input logic              err
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  // R2
  fast_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && popReq && !spWrEn && shadowValid) |=>
      (rdValid && rdCycle == 2'd1 && rdAddr == $past(sp) - STEP_V && sp == rdAddr));

  // R3
  slow_pop_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && popReq && !spWrEn && !shadowValid) |=> (!ready && !rdValid));

  // R3
  slow_pop_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> (ready && rdValid && rdCycle == 2'd2 && shadowValid));

  // R5
  sp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && spWrEn) |=> (!shadowValid && sp == $past(spWrData)));

  // R6
  push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && pushReq && !popReq && !spWrEn) |=>
      (wrValid && wrAddr == $past(sp) && sp == $past(sp) + STEP_V && shadowValid));

  // R7
  collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && popReq && spWrEn) |=> (err && !rdValid));

  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrValid}));

  // R10
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdCycle == 2'd0));

  // R11
  shadow_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    shadowValid |-> (shadowSp == sp - STEP_V));

endmodule

bind sp_shadow_unit sp_shadow_chk #(
  .ADDR_W (ADDR_W),
  .STEP   (STEP)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .popReq      (popReq),
  .pushReq     (pushReq),
  .spWrEn      (spWrEn),
  .spWrData    (spWrData),
  .ready       (ready),
  .rdValid     (rdValid),
  .rdAddr      (rdAddr),
  .rdCycle     (rdCycle),
  .wrValid     (wrValid),
  .wrAddr      (wrAddr),
  .sp          (sp),
  .shadowSp    (shadowSp),
  .shadowValid (shadowValid),
  .err         (err)
);

// File: tb/tb_sp_shadow_unit.sv
module tb_sp_shadow_unit;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW   = 32;
  localparam int unsigned STEP = 8;
  localparam logic [AW-1:0] RST_SP = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          popReq = 1'b0;
  logic          pushReq = 1'b0;
  logic          spWrEn = 1'b0;
  logic [AW-1:0] spWrData = '0;
  logic          ready, rdValid, wrValid, shadowValid, err;
  logic [AW-1:0] rdAddr, wrAddr, sp;
  logic [1:0]    rdCycle;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] expSp;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_shadow_unit #(.ADDR_W(AW), .STEP(STEP), .RESET_SP(RST_SP)) dut (
    .clk(clk), .rstN(rstN), .popReq(popReq), .pushReq(pushReq),
    .spWrEn(spWrEn), .spWrData(spWrData), .ready(ready),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdCycle(rdCycle),
    .wrValid(wrValid), .wrAddr(wrAddr), .sp(sp),
    .shadowValid(shadowValid), .err(err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    popReq = 1'b0; pushReq = 1'b0; spWrEn = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    @(negedge clk);
    expSp = RST_SP;
    chk("R1", "sp", sp, RST_SP);
    chk("R1", "shadowValid", shadowValid, 0);
    chk("R1", "ready", ready, 1);
    chk("R1", "rdValid/wrValid/err", {rdValid, wrValid, err}, 0);
    chk("R1", "rdCycle", rdCycle, 0);
  endtask

  task automatic testPush();
    pushReq = 1'b1;
    step();
    clearIn();
    chk("R6", "wrValid", wrValid, 1);
    chk("R6", "wrAddr", wrAddr, expSp);
    expSp = expSp + STEP;
    chk("R6", "sp", sp, expSp);
    chk("R6", "shadowValid", shadowValid, 1);
    chk("R10", "rdValid during push", rdValid, 0);
    step();
    chk("R10", "wrValid pulse", wrValid, 0);
  endtask

  task automatic testFastPop(input string req);
    popReq = 1'b1;
    step();
    clearIn();
    chk(req, "rdValid", rdValid, 1);
    chk(req, "rdCycle", rdCycle, 1);
    expSp = expSp - STEP;
    chk(req, "rdAddr", rdAddr, expSp);
    chk(req, "sp", sp, expSp);
    step();
    chk("R10", "rdValid pulse", rdValid, 0);
    chk("R10", "rdCycle idle", rdCycle, 0);
  endtask

  task automatic testLoad(input logic [AW-1:0] val);
    spWrEn = 1'b1; spWrData = val;
    step();
    clearIn();
    expSp = val;
    chk("R5", "sp", sp, val);
    chk("R5", "shadowValid", shadowValid, 0);
  endtask

  task automatic testSlowPop();
    popReq = 1'b1;
    step();
    popReq = 1'b0;
    chk("R3", "ready low", ready, 0);
    chk("R3", "rdValid in stall", rdValid, 0);
    pushReq = 1'b1;
    spWrEn = 1'b1; spWrData = 32'hDEAD_0000;
    step();
    clearIn();
    chk("R3", "rdValid", rdValid, 1);
    chk("R3", "rdCycle", rdCycle, 2);
    expSp = expSp - STEP;
    chk("R3", "rdAddr", rdAddr, expSp);
    chk("R9", "sp after ignored requests", sp, expSp);
    chk("R9", "no write for ignored push", wrValid, 0);
    chk("R4", "shadowValid after slow pop", shadowValid, 1);
    chk("R4", "ready", ready, 1);
    step();
    chk("R9", "no late write", wrValid, 0);
    chk("R9", "sp stable", sp, expSp);
  endtask

  task automatic testCollide(input logic [AW-1:0] val);
    popReq = 1'b1; spWrEn = 1'b1; spWrData = val;
    step();
    clearIn();
    expSp = val;
    chk("R7", "err", err, 1);
    chk("R7", "rdValid", rdValid, 0);
    chk("R7", "sp", sp, val);
    chk("R7", "shadowValid", shadowValid, 0);
    step();
    chk("R7", "err pulse", err, 0);
    chk("R7", "no late read", rdValid, 0);
  endtask

  task automatic testPopPush();
    popReq = 1'b1; pushReq = 1'b1;
    step();
    clearIn();
    expSp = expSp - STEP;
    chk("R8", "rdValid", rdValid, 1);
    chk("R8", "wrValid", wrValid, 0);
    chk("R8", "rdAddr", rdAddr, expSp);
    chk("R8", "sp", sp, expSp);
    step();
    chk("R8", "no late write", wrValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testPush();
    testPush();
    testFastPop("R2");
    testLoad(32'h0000_2000);
    testSlowPop();
    testFastPop("R4");
    testCollide(32'h0000_3000);
    testPush();
    testPopPush();
    testLoad(32'h0000_4000);
    testSlowPop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule